// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block holds the protection setting of an on-chip flash array and screens every program and erase request against it. On reset it copies a protection byte, supplied on an input by the logic that reads the flash configuration area, into its protection register. From then on software can rewrite the register, but only in the direction of more protection. A write that would leave fewer sectors guarded is dropped.

Protection always covers a run of sectors that ends at the highest address of the array. The register holds an enable bit and a 3-bit size code. When enabled, the top `size + 1` sectors are guarded. Each request is a program, a sector erase or a whole-block erase, and it carries a byte address. One cycle later the block answers with allow or reject. Any reject also sets a sticky violation flag, which software clears by pulsing a clear input.

Top module: `flash_prot_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the register loads from `cfg_byte`: bit 7 is the enable bit and bits 2:0 are the size code. `viol` and `resp_valid` go to 0.
- R2: Bits 6:3 of `prot_rd` always read 0, whatever value was loaded at reset or written.
- R3: A write (`wr_en` high, data encoded as in R1) takes effect on the next edge when the new guarded sector count is not smaller than the current one. The count is 0 when disabled and `size + 1` when enabled. A write that sets the enable bit while the register is disabled is therefore always accepted.
- R4: A write whose guarded count is smaller than the current one is ignored, and `prot_rd` keeps its value.
- R5: With the enable bit set, the top `size + 1` sectors of 2^SECT_LG bytes each are guarded. A program (`req_kind` 0), sector erase (1) or other code (3) whose address falls in a guarded sector is rejected.
- R6: A program or sector erase to an unguarded sector is allowed. When the enable bit is clear, no sector is guarded.
- R7: A block erase (`req_kind` 2) applies to the aligned 2^BLK_LG-byte block that contains the address. It is rejected if any sector of that block is guarded, even when the address itself is not in a guarded sector.
- R8: A rejected request sets `viol` on the same edge that its response appears. `viol` then stays set until it is cleared.
- R9: A `viol_clr` pulse clears `viol` on the next edge. If a rejected request arrives in the same cycle as the pulse, `viol` stays set.
- R10: `resp_valid` is `req_valid` delayed by one cycle. `resp_allow` carries the decision for that request, judged against the register value from before any write in the same cycle. `resp_allow` is 0 when there is no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the register from `cfg_byte` |
| cfg_byte | input | 8 | Protection byte read from the flash configuration area |
| wr_en | input | 1 | Software write strobe for the protection register |
| wr_data | input | 8 | Value to write |
| prot_rd | output | 8 | Current protection register value |
| viol_clr | input | 1 | Clear pulse for the violation flag |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 treated as program |
| req_addr | input | ADDR_W | Target byte address |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_allow | output | 1 | 1 = request allowed, 0 = rejected |
| viol | output | 1 | Sticky protection-violation flag |

## Verification
Assertions check the following on every cycle:
- The guarded sector count never shrinks outside reset.
- Responses follow requests after exactly one cycle.
- A reject always leaves the flag set.
- A clear with no competing reject always drops the flag.
- With protection disabled, every response is an allow.

The exact sector and block boundaries can only be shown by the bench's scenarios. These include the first guarded address, a block erase just below the guarded run, and writes that try to shrink or disable protection. The same holds for the bit layout loaded at reset and for a clear arriving in the same cycle as a violation.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

    typedef enum logic [1:0] {
        REQ_PROG   = 2'd0,
        REQ_SERASE = 2'd1,
        REQ_BERASE = 2'd2,
        REQ_OTHER  = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic       en;
        logic [2:0] size;
    } prot_cfg_t;

    localparam int EN_BIT = 7;

    function automatic prot_cfg_t cfg_from_byte(input logic [7:0] b);
        prot_cfg_t c;
        c.en   = b[EN_BIT];
        c.size = b[2:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input prot_cfg_t c);
        return {c.en, 4'b0000, c.size};
    endfunction

    // Guarded sector count: 0 when disabled, size+1 otherwise.
    function automatic logic [3:0] guarded_count(input prot_cfg_t c);
        return c.en ? ({1'b0, c.size} + 4'd1) : 4'd0;
    endfunction

    function automatic logic may_replace(input prot_cfg_t cur, input prot_cfg_t nxt);
        if (!cur.en) return 1'b1;
        if (!nxt.en) return 1'b0;
        return nxt.size >= cur.size;
    endfunction

endpackage

// File: rtl/fprot_reg.sv
module fprot_reg
    import fprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_byte,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output prot_cfg_t  cfg_q
);

    prot_cfg_t wr_cfg;
    logic      seen_run;

    assign wr_cfg = cfg_from_byte(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= cfg_from_byte(cfg_byte);
            seen_run <= 1'b0;
        end else begin
            seen_run <= 1'b1;
            if (wr_en && may_replace(cfg_q, wr_cfg)) begin
                cfg_q <= wr_cfg;
            end
        end
    end

    // R4: guarded region never shrinks once out of reset
    assert_no_shrink_R4: assert property (@(posedge clk) disable iff (rst)
        seen_run |-> (guarded_count(cfg_q) >= guarded_count($past(cfg_q))));

endmodule

// File: rtl/fprot_decide.sv
module fprot_decide
    import fprot_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SECT_LG = 9,
    parameter int BLK_LG  = 11
) (
    input  prot_cfg_t           cfg,
    input  req_kind_e           kind,
    input  logic [ADDR_W-1:0]   addr,
    output logic                allow
);

    localparam int              LIM_W    = ADDR_W + 1;
    localparam logic [LIM_W-1:0] TOP_END = LIM_W'(1) << ADDR_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((64'd1 << BLK_LG) - 64'd1);

    logic [LIM_W-1:0] span;
    logic [LIM_W-1:0] low_edge;
    logic [LIM_W-1:0] probe;

    always_comb begin
        span     = LIM_W'(guarded_count(cfg)) << SECT_LG;
        low_edge = TOP_END - span;
        if (kind == REQ_BERASE) begin
            // highest byte of the enclosing block decides for the whole block
            probe = {1'b0, addr | BLK_MASK};
        end else begin
            probe = {1'b0, addr};
        end
        allow = !(cfg.en && (probe >= low_edge));
    end

endmodule

// File: rtl/fprot_resp.sv
module fprot_resp (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic allow_c,
    input  logic viol_clr,
    output logic resp_valid,
    output logic resp_allow,
    output logic viol
);

    logic reject;
    assign reject = req_valid && !allow_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            viol       <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && allow_c;
            if (reject) begin
                viol <= 1'b1;
            end else if (viol_clr) begin
                viol <= 1'b0;
            end
        end
    end

    // R8: a rejected answer always comes with the flag up
    assert_reject_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_allow) |-> viol);

    // R9: a clear with no competing reject drops the flag
    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (viol_clr && !(req_valid && !allow_c)) |=> !viol);

    // R9: a reject wins over a simultaneous clear
    assert_reject_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !allow_c) |=> viol);

endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
    import fprot_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SECT_LG = 9,
    parameter int BLK_LG  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_byte,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        prot_rd,
    input  logic              viol_clr,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              viol
);

    prot_cfg_t cfg_q;
    req_kind_e kind;
    logic      allow_c;

    assign kind    = req_kind_e'(req_kind);
    assign prot_rd = cfg_to_byte(cfg_q);

    fprot_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .cfg_byte (cfg_byte),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q)
    );

    fprot_decide #(
        .ADDR_W  (ADDR_W),
        .SECT_LG (SECT_LG),
        .BLK_LG  (BLK_LG)
    ) u_decide (
        .cfg   (cfg_q),
        .kind  (kind),
        .addr  (req_addr),
        .allow (allow_c)
    );

    fprot_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .allow_c    (allow_c),
        .viol_clr   (viol_clr),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow),
        .viol       (viol)
    );

    // R10: one response per request, one cycle later
    assert_resp_latency_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R6: nothing is refused while protection is disabled
    assert_open_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_q.en) |=> resp_allow);

endmodule

// File: tb/tb_flash_prot_ctrl.sv
module tb_flash_prot_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 16;
    localparam int SECT_LG = 9;
    localparam int BLK_LG  = 11;
    localparam int NSECT   = 1 << (ADDR_W - SECT_LG);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        cfg_byte = 8'h00;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = 8'h00;
    logic [7:0]        prot_rd;
    logic              viol_clr = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic              resp_allow;
    logic              viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit       m_en;
    int       m_size;
    bit       m_viol;
    // expectations for the next sample
    bit       e_rv, e_ra, e_viol;
    logic [7:0] e_prot;
    string    t_prot, t_ra, t_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prot_ctrl #(.ADDR_W(ADDR_W), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)) dut (
        .clk(clk), .rst(rst), .cfg_byte(cfg_byte), .wr_en(wr_en), .wr_data(wr_data),
        .prot_rd(prot_rd), .viol_clr(viol_clr), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .viol(viol)
    );

    function automatic int count_of(bit en, int size);
        return en ? size + 1 : 0;
    endfunction

    function automatic bit sect_guarded(int idx);
        return m_en && (idx >= NSECT - (m_size + 1));
    endfunction

    function automatic bit exp_allow(int kind, int addr);
        int idx = addr >> SECT_LG;
        if (kind == 2) begin
            int first = (addr >> BLK_LG) << (BLK_LG - SECT_LG);
            for (int s = 0; s < (1 << (BLK_LG - SECT_LG)); s++)
                if (sect_guarded(first + s)) return 1'b0;
            return 1'b1;
        end
        return !sect_guarded(idx);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sample();
        check("R10 resp_valid", resp_valid, e_rv);
        check(t_ra, resp_allow, e_ra);
        check(t_viol, viol, e_viol);
        check(t_prot, prot_rd, e_prot);
        check("R2 reserved bits", prot_rd[6:3], 0);
    endtask

    // one cycle: check previous expectations, drive new inputs, predict
    task automatic drive(bit rv, int kind, int addr, bit we, logic [7:0] wd, bit clr);
        bit a, nen, acc;
        int nsz;
        @(negedge clk);
        sample();
        req_valid = rv; req_kind = kind[1:0]; req_addr = addr[ADDR_W-1:0];
        wr_en = we; wr_data = wd; viol_clr = clr;
        a = exp_allow(kind, addr);
        e_rv = rv;
        e_ra = rv && a;
        t_ra = (kind == 2) ? "R7 block erase" : (m_en ? "R5 guarded check" : "R6 open sector");
        if (rv && !a) begin
            m_viol = 1'b1; t_viol = clr ? "R9 reject beats clear" : "R8 sticky flag";
        end else if (clr) begin
            m_viol = 1'b0; t_viol = "R9 clear";
        end else begin
            t_viol = "R8 sticky flag";
        end
        e_viol = m_viol;
        if (we) begin
            nen = wd[7]; nsz = wd[2:0];
            acc = count_of(nen, nsz) >= count_of(m_en, m_size);
            if (acc) begin m_en = nen; m_size = nsz; t_prot = "R3 write accepted"; end
            else t_prot = "R4 write ignored";
        end
        e_prot = {m_en, 4'b0, 3'(m_size)};
    endtask

    task automatic do_reset(logic [7:0] b);
        @(negedge clk);
        rst = 1'b1; cfg_byte = b;
        req_valid = 0; wr_en = 0; viol_clr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_en = b[7]; m_size = b[2:0]; m_viol = 0;
        e_rv = 0; e_ra = 0; e_viol = 0; e_prot = {b[7], 4'b0, b[2:0]};
        t_prot = "R1 reset load"; t_ra = "R1 reset resp_allow"; t_viol = "R1 reset flag";
        sample();
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_en = 0; m_size = 0; m_viol = 0;

        // R1, R2: reset load with reserved bits set in the source byte
        do_reset(8'hFC);
        // size 4 -> 5 sectors, guarded from 0xF600
        drive(1, 0, 16'hF5FF, 0, 8'h00, 0);   // R6 just below edge
        drive(1, 0, 16'hF600, 0, 8'h00, 0);   // R5 first guarded byte
        drive(1, 2, 16'hF000, 0, 8'h00, 0);   // R7 block holds guarded sector
        drive(1, 2, 16'hE800, 0, 8'h00, 0);   // R7 block fully open
        drive(0, 0, 0, 1, 8'h83, 0);          // R4 shrink attempt
        drive(0, 0, 0, 1, 8'h04, 0);          // R4 disable attempt
        drive(1, 1, 16'hF600, 1, 8'h87, 1);   // R9 reject with clear, R3 grow
        drive(0, 0, 0, 0, 8'h00, 1);          // R9 clear
        drive(1, 1, 16'hF000, 0, 8'h00, 0);   // R5 grown region
        drive(0, 0, 0, 0, 8'h00, 0);

        // R6: disabled, then R3 enabling write
        do_reset(8'h05);
        drive(1, 2, 16'hF800, 0, 8'h00, 0);
        drive(1, 3, 16'hFFFF, 1, 8'h80, 0);
        drive(1, 3, 16'hFFFF, 0, 8'h00, 0);
        drive(1, 0, 16'hFDFF, 0, 8'h00, 0);
        drive(0, 0, 0, 0, 8'h00, 0);

        // random phase
        for (int r = 0; r < 4; r++) begin
            do_reset(8'($urandom));
            for (int i = 0; i < 700; i++) begin
                int addr = $urandom & 16'hFFFF;
                if ($urandom_range(1, 0) == 1) addr = addr | 16'hE000;
                drive($urandom_range(3, 0) != 0, $urandom_range(3, 0), addr,
                      $urandom_range(15, 0) == 0, 8'($urandom),
                      $urandom_range(7, 0) == 0);
            end
            drive(0, 0, 0, 0, 8'h00, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule